// File: doc/BRIEF.md
# SPI Flash Status Register Engine

This block is the device-side command logic that a serial flash uses to handle its status register over an SPI slave link in mode 0. Bytes arrive most significant bit first. The block decodes three commands: set-write-enable, status read and status write. A status write that is accepted starts a self-timed write cycle, and BUSY is set for the length of that cycle. The four block-protect bits are driven on a port so that neighbouring array logic can use them.

The SPI pins are brought into the system clock domain by a synchroniser chain. A bit engine finds the serial clock edges, puts the received bytes together and shifts the status byte out. A command state machine decides what each session does. Its states are:

- `ST_IDLE`: chip select is high.
- `ST_OPCODE`: the first byte is being received.
- `ST_RDSR`: the status byte is being streamed out.
- `ST_WREN_END`: a write-enable opcode is complete and the block waits for chip select to rise.
- `ST_WRSR_DATA`: the block is receiving the data byte of a status write.
- `ST_WRSR_END`: the data byte is complete and the block waits for chip select to rise.
- `ST_DISCARD`: the rest of the session is ignored.

The transitions are:

- From any state, a high chip select returns the machine to `ST_IDLE`.
- `ST_IDLE` goes to `ST_OPCODE` when chip select falls.
- At the end of the first byte, `ST_OPCODE` goes to `ST_RDSR`, `ST_WREN_END`, `ST_WRSR_DATA` or `ST_DISCARD`, depending on the opcode and the permission checks.
- `ST_WRSR_DATA` goes to `ST_WRSR_END` at the end of the data byte.
- Any further serial clock edge moves `ST_WREN_END` or `ST_WRSR_END` to `ST_DISCARD`.
- A rise of chip select in `ST_WREN_END` sets WEL.
- A rise of chip select in `ST_WRSR_END` starts the write cycle.
- The new bits are committed, and WEL is cleared, in the cycle in which the write cycle ends.

Top module: `spi_sr_engine`

## Requirements
- R1: After reset the status byte reads 0x00. This means SRP, the protect bits, WEL and BUSY are all 0, and `prot_bits` is 0.
- R2: A session of exactly eight bits carrying opcode 0x06, taken while BUSY is 0, sets WEL (status bit 1) when chip select rises.
- R3: Opcode 0x05 returns the status byte {SRP, 0, TB, BP2, BP1, BP0, WEL, BUSY}, bit 7 first. Each bit changes after a falling serial clock edge. The byte repeats for as long as chip select stays low.
- R4: Opcode 0x01 has no effect when WEL is 0.
- R5: A status write changes only bits 7, 5, 4, 3 and 2. Bit 6 always reads 0, and bits 1 and 0 never take the written data.
- R6: A status write runs only if chip select rises after exactly sixteen bits. A session with fewer or more bits leaves the status unchanged, WEL included.
- R7: An accepted status write holds BUSY at 1 for TW_CYCLES clock cycles, and the status read still works during that time.
- R8: When the write cycle ends, the new bits take effect and WEL is cleared to 0.
- R9: While BUSY is 1, every opcode except 0x05 is ignored.
- R10: When SRP is 1 and `wp_n` is low, a status write is locked out and WEL is kept. When SRP is 0, `wp_n` has no effect.
- R11: `prot_bits` equals status bits 5 down to 2 (TB, BP2, BP1, BP0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI serial clock, idles low |
| mosi | input | 1 | Serial data from the host |
| wp_n | input | 1 | Write-protect pin, active low |
| miso | output | 1 | Serial data to the host |
| prot_bits | output | 4 | Block-protect bits {TB, BP2, BP1, BP0} |

## Verification
The bench builds the engine with TW_CYCLES of 300 and a two-stage synchroniser. The serial clock runs at ten system clocks per bit. A write cycle therefore lasts longer than one full status read, so a poll issued just after a write is certain to see BUSY at 1, and a second command can be sent while the cycle is still running. With this short write time, a sweep of 48 data patterns (set-write-enable, status write, wait, read back) fits in the run. The sweep drives every writable bit and every read-only bit both high and low. The runt session and the overlong session, the WEL gate, and every combination of SRP and `wp_n` are each covered as single cases.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;

    localparam int unsigned BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OP_WREN = 8'h06;
    localparam logic [BYTE_W-1:0] OP_RDSR = 8'h05;
    localparam logic [BYTE_W-1:0] OP_WRSR = 8'h01;

    // writable bits: SRP(7) TB(5) BP2(4) BP1(3) BP0(2)
    localparam logic [BYTE_W-1:0] SR_WR_MASK = 8'hBC;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_RDSR,
        ST_WREN_END,
        ST_WRSR_DATA,
        ST_WRSR_END,
        ST_DISCARD
    } cmd_state_t;

endpackage

// File: rtl/spi_sr_sync.sv
module spi_sr_sync #(
    parameter int unsigned WIDTH   = 4,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/spi_sr_bitio.sv
module spi_sr_bitio
    import spi_sr_pkg::*;
#(
    parameter int unsigned BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_s,
    input  logic          sclk_s,
    input  logic          mosi_s,
    input  logic          tx_en,
    input  logic [BW-1:0] tx_byte,
    output logic          sclk_rise,
    output logic          cs_rise,
    output logic          byte_done,
    output logic [BW-1:0] rx_byte,
    output logic          miso
);

    localparam int unsigned CW = $clog2(BW);
    localparam logic [CW-1:0] LAST = CW'(BW - 1);

    logic          sclk_d, cs_d, sclk_fall;
    logic [CW-1:0] bit_cnt;
    logic [BW-1:0] shreg, snap;

    assign sclk_rise = sclk_s & ~sclk_d & ~cs_s;
    assign sclk_fall = ~sclk_s & sclk_d & ~cs_s;
    assign cs_rise   = cs_s & ~cs_d;
    assign byte_done = sclk_rise && (bit_cnt == LAST);
    assign rx_byte   = {shreg[BW-2:0], mosi_s};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d  <= 1'b0;
            cs_d    <= 1'b1;
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            sclk_d <= sclk_s;
            cs_d   <= cs_s;
            if (cs_s) begin
                bit_cnt <= '0;
            end else if (sclk_rise) begin
                bit_cnt <= bit_cnt + 1'b1;
                shreg   <= rx_byte;
            end
        end
    end

    // output side: new byte snapshot at each byte start, bit on each fall
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            miso <= 1'b0;
            snap <= '0;
        end else if (cs_s || !tx_en) begin
            miso <= 1'b0;
        end else if (sclk_fall) begin
            if (bit_cnt == '0) begin
                snap <= tx_byte;
                miso <= tx_byte[BW-1];
            end else begin
                miso <= snap[LAST - bit_cnt];
            end
        end
    end

endmodule

// File: rtl/spi_sr_timer.sv
module spi_sr_timer #(
    parameter int unsigned TW_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int unsigned CW = $clog2(TW_CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (start)          cnt <= CW'(TW_CYCLES);
        else if (cnt != '0)      cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));

endmodule

// File: rtl/spi_sr_engine.sv
module spi_sr_engine
    import spi_sr_pkg::*;
#(
    parameter int unsigned TW_CYCLES   = 64,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       mosi,
    input  logic       wp_n,
    output logic       miso,
    output logic [3:0] prot_bits
);

    logic cs_s, sclk_s, mosi_s, wp_s;
    logic sclk_rise, cs_rise, byte_done, tx_en;
    logic [BYTE_W-1:0] rx_byte, status, sr_nv, pend;
    logic wel, busy, wr_done, start_wr, wr_allowed;
    cmd_state_t state, state_nx;

    spi_sr_sync #(
        .WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1001)
    ) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({cs_n, sclk, mosi, wp_n}),
        .dout({cs_s, sclk_s, mosi_s, wp_s})
    );

    spi_sr_bitio #(.BW(BYTE_W)) u_bitio (
        .clk(clk), .rst_n(rst_n),
        .cs_s(cs_s), .sclk_s(sclk_s), .mosi_s(mosi_s),
        .tx_en(tx_en), .tx_byte(status),
        .sclk_rise(sclk_rise), .cs_rise(cs_rise),
        .byte_done(byte_done), .rx_byte(rx_byte), .miso(miso)
    );

    spi_sr_timer #(.TW_CYCLES(TW_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .start(start_wr), .busy(busy), .done(wr_done)
    );

    assign status     = {sr_nv[7:2], wel, busy};
    assign prot_bits  = sr_nv[5:2];
    assign wr_allowed = !busy && wel && !(sr_nv[7] && !wp_s);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        if (cs_s) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_OPCODE;
                ST_OPCODE: begin
                    if (byte_done) begin
                        if (rx_byte == OP_RDSR)
                            state_nx = ST_RDSR;
                        else if (rx_byte == OP_WREN && !busy)
                            state_nx = ST_WREN_END;
                        else if (rx_byte == OP_WRSR && wr_allowed)
                            state_nx = ST_WRSR_DATA;
                        else
                            state_nx = ST_DISCARD;
                    end
                end
                ST_WRSR_DATA: if (byte_done) state_nx = ST_WRSR_END;
                ST_WREN_END,
                ST_WRSR_END:  if (sclk_rise) state_nx = ST_DISCARD;
                ST_RDSR,
                ST_DISCARD:   state_nx = state;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // outputs and actions
    assign tx_en    = (state == ST_RDSR);
    assign start_wr = cs_rise && (state == ST_WRSR_END);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel   <= 1'b0;
            pend  <= '0;
            sr_nv <= '0;
        end else begin
            if (state == ST_WRSR_DATA && byte_done)
                pend <= rx_byte;
            if (wr_done) begin
                sr_nv <= (sr_nv & ~SR_WR_MASK) | (pend & SR_WR_MASK);
                wel   <= 1'b0;
            end else if (cs_rise && state == ST_WREN_END) begin
                wel <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_sr_engine_chk.sv
module spi_sr_engine_chk #(
    parameter int unsigned TW_CYCLES = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       wel,
    input logic [7:0] sr_nv
);

    logic [31:0] busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len <= '0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= '0;
    end

    a_r5_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_nv[6] == 1'b0) && (sr_nv[1:0] == 2'b00));

    a_r4_write_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> wel);

    a_r8_wel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel);

    a_r8_commit_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy) |-> $stable(sr_nv));

    a_r7_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == TW_CYCLES));

endmodule

bind spi_sr_engine spi_sr_engine_chk #(.TW_CYCLES(TW_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .wel(wel), .sr_nv(sr_nv)
);

// File: tb/spi_sr_engine_tb.sv
module spi_sr_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int TW         = 300;
    localparam int HALF       = 5;
    localparam int WATCHDOG   = 190000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, wp_n = 1'b1;
    logic miso;
    logic [3:0] prot_bits;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_sr_engine #(.TW_CYCLES(TW), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .mosi(mosi), .wp_n(wp_n), .miso(miso), .prot_bits(prot_bits)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic sel();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic desel();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(2 * HALF);
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = tx[i];
            wait_clk(HALF);
            rx[i] = miso;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        sel(); xfer(op, 8, d); desel();
    endtask

    task automatic wrsr(input logic [7:0] v, input int nbits);
        logic [7:0] d;
        sel(); xfer(8'h01, 8, d); xfer(v, nbits, d);
        if (nbits > 8) xfer(8'h00, nbits - 8, d);
        desel();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        sel(); xfer(8'h05, 8, d); xfer(8'h00, 8, s); desel();
    endtask

    initial begin : main
        logic [7:0] s, s2, s3, d, exp;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);

        // R1 reset state
        rdsr(s);
        chk("R1 status", s, 8'h00);
        chk("R1 prot", {4'h0, prot_bits}, 8'h00);

        // R4 write without WEL
        wrsr(8'hFC, 8);
        wait_clk(TW + 20);
        rdsr(s);
        chk("R4 no wel", s, 8'h00);

        // R2 write enable
        cmd1(8'h06);
        rdsr(s);
        chk("R2 wel set", s, 8'h02);

        // R7 busy visible, R9 commands ignored while busy
        wrsr(8'hFF, 8);
        rdsr(s);
        chk("R7 busy poll", s, 8'h03);
        wrsr(8'h00, 8);
        wait_clk(TW + 20);
        rdsr(s);
        chk("R8 committed R5 mask", s, 8'hBC);
        chk("R11 prot", {4'h0, prot_bits}, 8'h0F);

        // R6 runt session and overlong session
        cmd1(8'h06);
        wrsr(8'h00, 7);
        wait_clk(TW + 20);
        rdsr(s);
        chk("R6 seven bits", s, 8'hBE);
        wrsr(8'h00, 9);
        wait_clk(TW + 20);
        rdsr(s);
        chk("R6 nine bits", s, 8'hBE);

        // R3 repeated status byte
        sel(); xfer(8'h05, 8, d); xfer(8'h00, 8, s); xfer(8'h00, 8, s2); xfer(8'h00, 8, s3); desel();
        chk("R3 byte1", s, 8'hBE);
        chk("R3 byte2", s2, 8'hBE);
        chk("R3 byte3", s3, 8'hBE);

        // R10 lockout: SRP=1 and wp low
        wp_n = 1'b0;
        wrsr(8'h00, 8);
        wait_clk(TW + 20);
        rdsr(s);
        chk("R10 locked", s, 8'hBE);
        wp_n = 1'b1;
        wrsr(8'h00, 8);
        wait_clk(TW + 20);
        rdsr(s);
        chk("R10 wp high allows", s, 8'h00);
        wp_n = 1'b0;
        cmd1(8'h06);
        wrsr(8'h3C, 8);
        wait_clk(TW + 20);
        rdsr(s);
        chk("R10 srp0 ignores wp", s, 8'h3C);
        wp_n = 1'b1;

        // R5 R8 R11 sweep over data patterns
        for (int i = 0; i < 48; i++) begin
            d = 8'((i * 37 + 11) & 255);
            exp = d & 8'hBC;
            cmd1(8'h06);
            wrsr(d, 8);
            wait_clk(TW + 20);
            rdsr(s);
            chk("R5 sweep", s, exp);
            chk("R11 sweep", {4'h0, prot_bits}, {4'h0, exp[5:2]});
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule